// File: doc/BRIEF.md
# Sync Edge Detector with Selectable Reference Edges

This block takes the raw horizontal and vertical sync inputs of a video source, sampled in the dot-clock domain. It gives the display timing logic two single-cycle strobes. The first is `line_start`, which marks the start of each scan line. The second is `field_start`, which marks the start of each field.

A polarity bit says which input level counts as active. Three edge-select bits set the detection points:

- which HSYNC edge begins a line;
- which VSYNC edge arms the field detector;
- which HSYNC edge then releases the field strobe.

When all three edge-select bits are set, the field strobe is released a fixed number of dot clocks after the HSYNC leading edge, instead of on an edge. The "leading edge" of a sync input is its transition into the active level. The "trailing edge" is its transition back to the inactive level.

Both inputs first pass through a two-stage synchronizer. A one-bit pending flag records that a selected VSYNC edge has been seen. The next HSYNC reference point turns that flag into `field_start` and clears it. The VSYNC pulse is expected to last 2 to 20 lines. It must also stay stable for at least 2 lines around the detection point, so each field yields exactly one reference match.

Top module: `osd_sync_detect`

## Requirements
- R1: A change on `hsync_in` or `vsync_in` becomes visible to the edge logic after exactly two dot-clock stages. With `cfg_h_lead`=1, an active transition of `hsync_in` set up before clock edge k raises `line_start` in the cycle after edge k+1.
- R2: With `cfg_pol`=0 the sync inputs are active when low. With `cfg_pol`=1 they are active when high. Edge naming follows the active level.
- R3: `line_start` pulses on the HSYNC leading edge when `cfg_h_lead`=1, and on the HSYNC trailing edge when `cfg_h_lead`=0.
- R4: `line_start` is high for exactly one cycle per HSYNC pulse.
- R5: `cfg_v_trail` selects the VSYNC edge that arms the field detector: 0 for the leading edge, 1 for the trailing edge. Unless all three edge bits are 1, `cfg_vref_trail` selects the HSYNC reference edge: 0 for the leading edge, 1 for the trailing edge. `field_start` pulses at the first reference point after the arming edge.
- R6: When `cfg_v_trail`, `cfg_vref_trail` and `cfg_h_lead` are all 1, the reference point falls 10 dot clocks (`VREF_OFFSET`) after the cycle in which the HSYNC leading edge is detected. In that cycle `line_start` also pulses.
- R7: Each arming VSYNC edge produces exactly one `field_start` pulse of one cycle. No `field_start` occurs without an arming edge.
- R8: If an arming VSYNC edge is detected in the same cycle as a reference point, that reference point is not used. `field_start` waits for the next reference point.
- R9: While the synchronous active-high `rst` is asserted, both outputs are low. Reset also clears the pending flag, the offset counter and the synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| cfg_pol | input | 1 | 1: syncs active high, 0: active low |
| cfg_v_trail | input | 1 | Arming VSYNC edge, 1: trailing |
| cfg_vref_trail | input | 1 | HSYNC reference edge for field detection, 1: trailing |
| cfg_h_lead | input | 1 | Line-start HSYNC edge, 1: leading, 0: trailing |
| line_start | output | 1 | One-cycle line strobe |
| field_start | output | 1 | One-cycle field strobe |

## Verification
The arming VSYNC edge and an HSYNC reference point can land in the same cycle. This is provoked by moving both sync inputs into their active level on the same clock, with the leading edge selected for both. The bench then checks that the field strobe comes out one full line later, at the next line strobe, and not in the coincident cycle. A behavioural model of the input history is also compared on every clock under each polarity and edge-select setting. This includes the offset mode, where the field strobe must trail a line strobe by exactly ten cycles.

// File: rtl/osd_sync_pkg.sv
package osd_sync_pkg;

    typedef struct packed {
        logic pol;
        logic v_trail;
        logic vref_trail;
        logic h_lead;
    } sync_cfg_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } edge_pair_t;

    function automatic logic pick_edge(input edge_pair_t e, input logic use_trail);
        return use_trail ? e.trail : e.lead;
    endfunction

    function automatic logic offset_mode(input sync_cfg_t c);
        return c.v_trail & c.vref_trail & c.h_lead;
    endfunction

endpackage

// File: rtl/sync_edge_sampler.sv
module sync_edge_sampler
    import osd_sync_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active_high,
    input  logic       pin,
    output edge_pair_t edges
);
    logic level;
    logic [STAGES:0] chain;

    assign level = active_high ? pin : ~pin;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= level;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign edges.lead  =  chain[STAGES-1] & ~chain[STAGES];
    assign edges.trail = ~chain[STAGES-1] &  chain[STAGES];

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        edges.lead |-> $past(level, STAGES)); // R1

endmodule

// File: rtl/hsync_ref_timer.sv
module hsync_ref_timer #(
    parameter int OFFSET = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic fire
);
    localparam int W = $clog2(OFFSET + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= W'(OFFSET);
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign fire = (cnt == W'(1));

    AST_REF_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire); // R6

endmodule

// File: rtl/osd_sync_detect.sv
module osd_sync_detect
    import osd_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int VREF_OFFSET = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    input  logic vsync_in,
    input  logic cfg_pol,
    input  logic cfg_v_trail,
    input  logic cfg_vref_trail,
    input  logic cfg_h_lead,
    output logic line_start,
    output logic field_start
);
    sync_cfg_t  cfg;
    edge_pair_t h_e;
    edge_pair_t v_e;
    logic       late_ref;
    logic       v_ref;
    logic       v_hit;
    logic       pending;

    assign cfg = '{pol: cfg_pol, v_trail: cfg_v_trail,
                   vref_trail: cfg_vref_trail, h_lead: cfg_h_lead};

    sync_edge_sampler #(.STAGES(SYNC_STAGES)) u_hs (
        .clk(clk), .rst(rst), .active_high(cfg.pol), .pin(hsync_in), .edges(h_e));

    sync_edge_sampler #(.STAGES(SYNC_STAGES)) u_vs (
        .clk(clk), .rst(rst), .active_high(cfg.pol), .pin(vsync_in), .edges(v_e));

    hsync_ref_timer #(.OFFSET(VREF_OFFSET)) u_tmr (
        .clk(clk), .rst(rst), .start(h_e.lead), .fire(late_ref));

    assign v_ref = offset_mode(cfg) ? late_ref : pick_edge(h_e, cfg.vref_trail);
    assign v_hit = pick_edge(v_e, cfg.v_trail);

    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= v_hit | (pending & ~v_ref);
    end

    assign line_start  = pick_edge(h_e, ~cfg.h_lead);
    assign field_start = pending & v_ref;

    AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start); // R4

    AST_FIELD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        field_start |=> !field_start); // R7

    AST_FLAG_DROPS: assert property (@(posedge clk) disable iff (rst)
        (field_start && !v_hit) |=> !field_start && !pending); // R7

    AST_RST_QUIET: assert property (@(posedge clk)
        rst |=> !field_start); // R9

endmodule

// File: tb/osd_sync_detect_bench.sv
module osd_sync_detect_bench;
    localparam int LINE = 40;
    localparam int HPW  = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic h_act = 1'b0, v_act = 1'b0;
    logic cfg_pol = 1'b1, cfg_v_trail = 1'b0, cfg_vref_trail = 1'b0, cfg_h_lead = 1'b0;
    logic hsync_in, vsync_in, line_start, field_start;

    assign hsync_in = cfg_pol ? h_act : ~h_act;
    assign vsync_in = cfg_pol ? v_act : ~v_act;

    always #10 clk = ~clk;

    osd_sync_detect u_osd_sync_detect (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .cfg_pol(cfg_pol), .cfg_v_trail(cfg_v_trail), .cfg_vref_trail(cfg_vref_trail),
        .cfg_h_lead(cfg_h_lead), .line_start(line_start), .field_start(field_start));

    int checks = 0, fails = 0, cyc = 0;
    string cur_req = "R9";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural model: history of active levels seen per clock
    int hq[$], vq[$];
    int last_lead = -1000;
    bit m_flag = 0, pv_edge = 0, pref = 0, exp_line = 0, exp_field = 0;

    always @(posedge clk) begin
        bit hl, ht, vl, vt, href, vedge;
        cyc++;
        if (rst) begin
            m_flag = 0;
            hq = {0, 0, 0, 0};
            vq = {0, 0, 0, 0};
            last_lead = -1000;
        end else begin
            m_flag = pv_edge | (m_flag & ~pref);
            hq.push_front(int'(h_act));
            vq.push_front(int'(v_act));
            void'(hq.pop_back());
            void'(vq.pop_back());
        end
        hl = hq[1] == 1 && hq[2] == 0;
        ht = hq[1] == 0 && hq[2] == 1;
        vl = vq[1] == 1 && vq[2] == 0;
        vt = vq[1] == 0 && vq[2] == 1;
        if (hl) last_lead = cyc;
        if (cfg_v_trail && cfg_vref_trail && cfg_h_lead) href = (cyc - last_lead == 10);
        else href = cfg_vref_trail ? ht : hl;
        vedge = cfg_v_trail ? vt : vl;
        exp_line  = cfg_h_lead ? hl : ht;
        exp_field = m_flag & href;
        pv_edge = rst ? 0 : vedge;
        pref    = rst ? 0 : href;
    end

    int n_ls = 0, n_fs = 0, fs_cyc = -1, fs_gap = -1, last_ls = -1;
    int ls_q[$];

    always @(negedge clk) begin
        chk(line_start == exp_line, {cur_req, " line_start"}, line_start, exp_line);
        chk(field_start == exp_field, {cur_req, " field_start"}, field_start, exp_field);
        if (field_start) begin
            n_fs++;
            fs_cyc = cyc;
            fs_gap = cyc - last_ls;
        end
        if (line_start) begin
            n_ls++;
            last_ls = cyc;
            ls_q.push_back(cyc);
        end
    end

    task automatic restart(input logic p, input logic vt, input logic vr, input logic hl);
        @(negedge clk);
        rst = 1'b1; h_act = 1'b0; v_act = 1'b0;
        cfg_pol = p; cfg_v_trail = vt; cfg_vref_trail = vr; cfg_h_lead = hl;
        repeat (3) @(negedge clk);
        n_ls = 0; n_fs = 0; fs_cyc = -1; fs_gap = -1; last_ls = -1;
        ls_q.delete();
        rst = 1'b0;
    endtask

    // lines of LINE cycles; vsync goes active at (von_line, von_c), inactive at line voff_line
    task automatic frame(input int nlines, input int von_line, input int von_c, input int voff_line);
        for (int l = 0; l < nlines; l++) begin
            for (int c = 0; c < LINE; c++) begin
                h_act = (c < HPW);
                if (l == von_line && c == von_c) v_act = 1'b1;
                if (l == voff_line && c == 20) v_act = 1'b0;
                @(negedge clk);
            end
        end
        repeat (12) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        #(20ns * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset holds outputs low while inputs move
        cur_req = "R9";
        rst = 1'b1;
        repeat (2) @(negedge clk);
        h_act = 1'b1; v_act = 1'b1;
        repeat (3) @(negedge clk);
        chk(!line_start && !field_start, "R9 outputs in reset", {line_start, field_start}, 0);
        h_act = 1'b0; v_act = 1'b0;

        // R2 R3 R5: active-low inputs, trailing line edge, leading vsync/href edges
        restart(1'b0, 1'b0, 1'b0, 1'b0);
        cur_req = "R2 R3 R5";
        frame(6, 1, 15, 4);
        chk(n_ls == 6, "R3 line count trailing", n_ls, 6);
        chk(n_fs == 1, "R7 one field per vsync", n_fs, 1);
        chk(ls_q.size() > 0 && ls_q[0] % LINE != 0, "R2 active-low edge seen", n_ls, 6);

        // R5: trailing vsync edge, trailing href, active high
        restart(1'b1, 1'b1, 1'b1, 1'b0);
        cur_req = "R5";
        frame(7, 1, 15, 4);
        chk(n_fs == 1, "R5 field on trailing vsync", n_fs, 1);
        chk(n_ls == 7, "R4 one line strobe per pulse", n_ls, 7);

        // R6: offset mode
        restart(1'b1, 1'b1, 1'b1, 1'b1);
        cur_req = "R6";
        frame(7, 1, 15, 4);
        chk(n_fs == 1, "R6 field count", n_fs, 1);
        chk(fs_gap == 10, "R6 offset from line strobe", fs_gap, 10);

        // R1: latency, active-low, leading line edge, trailing href
        restart(1'b0, 1'b0, 1'b1, 1'b1);
        cur_req = "R1 R3";
        repeat (4) @(negedge clk);
        h_act = 1'b1;
        @(negedge clk);
        chk(line_start == 1'b0, "R1 not after one stage", line_start, 0);
        @(negedge clk);
        chk(line_start == 1'b1, "R1 after two stages", line_start, 1);
        @(negedge clk);
        chk(line_start == 1'b0, "R4 pulse one cycle", line_start, 0);
        repeat (4) @(negedge clk);
        h_act = 1'b0;
        repeat (40) @(negedge clk);
        chk(n_fs == 0, "R7 no field without vsync", n_fs, 0);

        // R8: vsync leading edge coincides with href leading edge
        restart(1'b1, 1'b0, 1'b0, 1'b1);
        cur_req = "R8";
        frame(5, 1, 0, 4);
        chk(n_fs == 1, "R8 field count", n_fs, 1);
        chk(ls_q.size() >= 3 && fs_cyc == ls_q[2], "R8 field deferred one line",
            fs_cyc, ls_q.size() >= 3 ? ls_q[2] : -1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule